// File: doc/BRIEF.md
# Fuse Shadow Register Reload Engine

This block keeps a bank of shadow registers that mirror a one-time-programmable fuse array, so bus reads never wait on the slow fuse cells. A reload sequencer walks the fuse array one word at a time and copies every word into its shadow. A reload is started by a bus command or by a request pulse from the fuse programming logic after a burn. While the reload runs, the busy and reload status bits stay high, and both drop by themselves once the last word has been copied.

Per-word-group read and write locks come from a designated lock fuse word. They are captured during a reload and take effect only when that reload finishes. A read of a read-locked shadow returns the marker 0xBADABADA. Any refused access raises a sticky error bit. While that bit is set, shadow reads return the marker, shadow writes are dropped, and reload starts are ignored, until software clears the bit. Bus requests use a valid/ready handshake. Read responses also use valid/ready and can be stalled by the receiver. A stalled response blocks new requests until the receiver takes it.

Top module: `fuse_shadow_reload`

## Requirements
- R1: After reset the control word reads 0, the timing register reads 32'h0002_0000, every shadow reads 0 and no lock is active.
- R2: Shadow word i sits at byte address 0x400 + 0x10*i for i below NWORDS. A read of an address that is unaligned to the 0x10 stride or lies past the last word returns 0, and a write to such an address changes nothing.
- R3: Writing a word with bit 10 set to the set alias (0x004), or pulsing reload_req, starts a reload when no reload is running and the error bit is clear. From the next cycle the control word (0x000) reads with bit 10 (reload) and bit 8 (busy) set, and reload_busy is high.
- R4: During a reload, fuse_rd_en is high and fuse_addr steps from 0 up to NWORDS-1. Each word is held for S+1 cycles, where S is timing bits 21:16 (0x010). Each shadow is loaded with fuse_rdata on the last cycle of its word. After NWORDS*(S+1) cycles, bits 10 and 8 and reload_busy clear by themselves.
- R5: A bus write to a shadow while a reload runs is refused: error bit 9 is set and the shadow keeps its value.
- R6: A bus write to a write-locked shadow sets error bit 9 and leaves the shadow unchanged.
- R7: A bus read of a read-locked shadow returns 0xBADABADA and sets error bit 9.
- R8: Error bit 9 stays set until a word with bit 9 set is written to the clear alias (0x008). While it is set, shadow reads return 0xBADABADA, shadow writes are dropped, and reload starts from either source are ignored.
- R9: Word LOCK_IDX (default 0) of the fuse array is the lock word. Bit g read-locks group g and bit 16+g write-locks group g, where group g is shadows g*NWORDS/16 to (g+1)*NWORDS/16-1. The locks captured during a reload apply only after that reload has ended.
- R10: A request is accepted when req_valid and req_ready are both high. A read's response appears with rsp_valid one cycle later. While rsp_valid is high and rsp_ready is low, the response holds steady and req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request can be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_rdata | output | 32 | Read response data |
| reload_req | input | 1 | Reload request pulse from the programming logic |
| reload_busy | output | 1 | Reload in progress |
| fuse_rd_en | output | 1 | Fuse read strobe |
| fuse_addr | output | IDX_W | Fuse word being read |
| fuse_rdata | input | 32 | Fuse word data |

## Verification
The bench runs reloads with three strobe lengths (2, 0 and 5). The total busy time then tells whether the per-word hold follows the timing field and whether the sequencer skips or repeats words. Some accesses hit a word that has already been copied during a reload, and some hit a word in a locked group before and after the reload ends. These separate a refused write from a write that the reload merely overwrote, and they show whether locks commit early. Accesses to locked and unlocked words, both with the error bit set and with it clear, show whether the sticky error gates reads, writes and both reload sources. A stalled response with a second request queued behind it shows whether back-pressure holds the data and blocks new requests.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int OFF_CTRL    = 'h000;
  localparam int OFF_SET     = 'h004;
  localparam int OFF_CLR     = 'h008;
  localparam int OFF_TIMING  = 'h010;
  localparam int SHADOW_BASE = 'h400;

  localparam int BUSY_BIT   = 8;
  localparam int ERR_BIT    = 9;
  localparam int RELOAD_BIT = 10;

  localparam int STRB_LSB = 16;
  localparam int STRB_W   = 6;

  localparam int LOCK_GROUPS = 16;

  localparam logic [31:0] LOCKED_MARK = 32'hBADA_BADA;

  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/fsr_reload_seq.sv
module fsr_reload_seq import fsr_pkg::*; #(
  parameter int NWORDS = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STRB_W-1:0] strobe_len,
  input  logic [31:0]       fuse_rdata,
  output logic              busy,
  output logic              fuse_rd_en,
  output logic [IDX_W-1:0]  fuse_addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic [31:0]       cap_data,
  output logic              last_cap
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [STRB_W-1:0] cnt_q;
  logic              word_end;

  assign word_end = (state_q == SEQ_RUN) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start) begin
        state_q <= SEQ_RUN;
        idx_q   <= '0;
        cnt_q   <= strobe_len;
      end
    end else if (word_end) begin
      cnt_q <= strobe_len;
      if (idx_q == LAST_IDX) state_q <= SEQ_IDLE;
      else                   idx_q   <= idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy       = (state_q == SEQ_RUN);
  assign fuse_rd_en = busy;
  assign fuse_addr  = idx_q;
  assign cap_en     = word_end;
  assign cap_idx    = idx_q;
  assign cap_data   = fuse_rdata;
  assign last_cap   = word_end && (idx_q == LAST_IDX);
endmodule

// File: rtl/fsr_shadow_array.sv
module fsr_shadow_array import fsr_pkg::*; #(
  parameter int NWORDS   = 64,
  parameter int IDX_W    = 6,
  parameter int LOCK_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [31:0]      cap_data,
  input  logic             last_cap,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      rd_data,
  output logic             rd_locked,
  output logic             wr_locked
);
  localparam int GSZ = NWORDS / LOCK_GROUPS;
  localparam logic [IDX_W-1:0] LOCK_W = IDX_W'(LOCK_IDX);

  logic [31:0] words [NWORDS];
  logic [LOCK_GROUPS-1:0] rlk_q, wlk_q, rlk_pend, wlk_pend;
  logic [LOCK_GROUPS-1:0] rlk_new, wlk_new;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   word_q <= '0;
      else if (cap_en && cap_idx == IDX_W'(w))      word_q <= cap_data;
      else if (bus_we && acc_idx == IDX_W'(w))      word_q <= bus_wdata;
    end
    assign words[w] = word_q;
  end

  // lock word seen in this same cycle still counts for the commit
  assign rlk_new = (cap_en && cap_idx == LOCK_W) ? cap_data[LOCK_GROUPS-1:0] : rlk_pend;
  assign wlk_new = (cap_en && cap_idx == LOCK_W) ? cap_data[16 +: LOCK_GROUPS] : wlk_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlk_pend <= '0;
      wlk_pend <= '0;
      rlk_q    <= '0;
      wlk_q    <= '0;
    end else begin
      rlk_pend <= rlk_new;
      wlk_pend <= wlk_new;
      if (last_cap) begin
        rlk_q <= rlk_new;
        wlk_q <= wlk_new;
      end
    end
  end

  assign rd_data = words[acc_idx];

  always_comb begin
    rd_locked = 1'b0;
    wr_locked = 1'b0;
    for (int g = 0; g < LOCK_GROUPS; g++) begin
      if (int'(acc_idx) >= g * GSZ && int'(acc_idx) < (g + 1) * GSZ) begin
        rd_locked = rlk_q[g];
        wr_locked = wlk_q[g];
      end
    end
  end
endmodule

// File: rtl/fuse_shadow_reload.sv
module fuse_shadow_reload import fsr_pkg::*; #(
  parameter int          NWORDS     = 64,
  parameter int          AW         = 13,
  parameter int          LOCK_IDX   = 0,
  parameter logic [31:0] TIMING_RST = 32'h0002_0000,
  localparam int         IDX_W      = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  input  logic             reload_req,
  output logic             reload_busy,
  output logic             fuse_rd_en,
  output logic [IDX_W-1:0] fuse_addr,
  input  logic [31:0]      fuse_rdata
);
  logic [31:0]      timing_q;
  logic             err_q;
  logic             rsp_valid_q;
  logic [31:0]      rsp_data_q;
  logic             acc, is_ctrl, is_set, is_clr, is_tim, is_sh;
  logic [AW-1:0]    rel;
  logic [IDX_W-1:0] sh_idx;
  logic             seq_busy, cap_en, last_cap, rd_lk, wr_lk;
  logic [IDX_W-1:0] cap_idx;
  logic [31:0]      cap_data, sh_rdata, rd_val;
  logic             start, sh_we, refused, clr_err;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;

  assign is_ctrl = (req_addr == AW'(OFF_CTRL));
  assign is_set  = (req_addr == AW'(OFF_SET));
  assign is_clr  = (req_addr == AW'(OFF_CLR));
  assign is_tim  = (req_addr == AW'(OFF_TIMING));
  assign rel     = req_addr - AW'(SHADOW_BASE);
  assign is_sh   = (req_addr >= AW'(SHADOW_BASE)) && (req_addr[3:0] == 4'd0) &&
                   (rel[AW-1:4] < (AW-4)'(NWORDS));
  assign sh_idx  = rel[IDX_W+3:4];

  assign start   = !seq_busy && !err_q &&
                   (reload_req || (acc && req_write && is_set && req_wdata[RELOAD_BIT]));
  assign sh_we   = acc && req_write && is_sh && !seq_busy && !wr_lk && !err_q;
  assign refused = acc && is_sh && (req_write ? (seq_busy || wr_lk) : rd_lk);
  assign clr_err = acc && req_write && is_clr && req_wdata[ERR_BIT];

  always_comb begin
    rd_val = '0;
    if (is_ctrl) begin
      rd_val[BUSY_BIT]   = seq_busy;
      rd_val[ERR_BIT]    = err_q;
      rd_val[RELOAD_BIT] = seq_busy;
    end else if (is_tim) begin
      rd_val = timing_q;
    end else if (is_sh) begin
      rd_val = (err_q || rd_lk) ? LOCKED_MARK : sh_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q    <= TIMING_RST;
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (acc && req_write && is_tim) timing_q <= req_wdata;
      if (clr_err)      err_q <= 1'b0;
      else if (refused) err_q <= 1'b1;
      if (acc && !req_write) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_val;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  fsr_reload_seq #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strobe_len(timing_q[STRB_LSB +: STRB_W]), .fuse_rdata(fuse_rdata),
    .busy(seq_busy), .fuse_rd_en(fuse_rd_en), .fuse_addr(fuse_addr),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(cap_data), .last_cap(last_cap)
  );

  fsr_shadow_array #(.NWORDS(NWORDS), .IDX_W(IDX_W), .LOCK_IDX(LOCK_IDX)) u_arr (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(cap_data),
    .last_cap(last_cap), .bus_we(sh_we), .acc_idx(sh_idx), .bus_wdata(req_wdata),
    .rd_data(sh_rdata), .rd_locked(rd_lk), .wr_locked(wr_lk)
  );

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_data_q;
  assign reload_busy = seq_busy;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker import fsr_pkg::*; #(
  parameter int NWORDS = 64,
  parameter int AW     = 13,
  parameter int IDX_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             reload_busy,
  input logic [IDX_W-1:0] fuse_addr,
  input logic             err_q
);
  logic          acc, wr_sh, set_go, clr_go;
  logic [AW-1:0] rel;

  assign acc    = req_valid && req_ready;
  assign rel    = req_addr - AW'(SHADOW_BASE);
  assign wr_sh  = acc && req_write && (req_addr >= AW'(SHADOW_BASE)) &&
                  (req_addr[3:0] == 4'd0) && (rel[AW-1:4] < (AW-4)'(NWORDS));
  assign set_go = acc && req_write && (req_addr == AW'(OFF_SET)) && req_wdata[RELOAD_BIT];
  assign clr_go = acc && req_write && (req_addr == AW'(OFF_CLR)) && req_wdata[ERR_BIT];

  assert_set_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_go && !reload_busy && !err_q |=> reload_busy);

  assert_ends_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reload_busy) |-> $past(fuse_addr) == IDX_W'(NWORDS - 1));

  assert_addr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_busy && $past(reload_busy) |->
      (fuse_addr == $past(fuse_addr)) || (fuse_addr == $past(fuse_addr) + 1'b1));

  assert_busy_write_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sh && reload_busy |=> err_q);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr_go |=> err_q);

  assert_err_blocks_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !reload_busy |=> !reload_busy);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
endmodule

bind fuse_shadow_reload fsr_checker #(.NWORDS(NWORDS), .AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .reload_busy(reload_busy), .fuse_addr(fuse_addr), .err_q(err_q)
);

// File: tb/fuse_shadow_reload_tb.sv
module fuse_shadow_reload_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 64;
  localparam int AW  = 13;
  localparam int IW  = 6;
  localparam int GSZ = NW / 16;
  localparam logic [31:0] MARK = 32'hBADA_BADA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, reload_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, reload_busy, fuse_rd_en;
  logic [31:0] rsp_rdata, fuse_rdata;
  logic [IW-1:0] fuse_addr;

  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] fuse_val(input int i);
    if (i == 0) return 32'h0008_0004;  // read-lock group 2, write-lock group 3
    return 32'hA500_0000 ^ (i * 32'h0101_0101);
  endfunction

  function automatic logic [AW-1:0] sa(input int i);
    return AW'(32'h400 + i * 16);
  endfunction

  assign fuse_rdata = fuse_val(int'(fuse_addr));

  fuse_shadow_reload #(.NWORDS(NW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .reload_req(reload_req), .reload_busy(reload_busy), .fuse_rd_en(fuse_rd_en),
    .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_sh [NW];
  bit          m_busy, m_err, m_rv;
  int          m_idx, m_cnt;
  logic [15:0] m_rlk, m_wlk, m_pr, m_pw;
  logic [31:0] m_tim, m_rd, m_val;
  bit          m_acc, m_start, m_bad, m_clr, m_shw;
  int          m_si;

  function automatic int sh_of(input logic [AW-1:0] a);
    if (a >= 13'h400 && a[3:0] == 4'd0 && ((int'(a) - 'h400) >> 4) < NW)
      return (int'(a) - 'h400) >> 4;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) m_sh[i] = '0;
      m_busy = 0; m_err = 0; m_rv = 0; m_idx = 0; m_cnt = 0;
      m_rlk = '0; m_wlk = '0; m_pr = '0; m_pw = '0;
      m_tim = 32'h0002_0000; m_rd = '0;
    end else begin
      m_acc = req_valid && (!m_rv || rsp_ready);
      m_si  = sh_of(req_addr);
      m_val = 32'h0;
      if (req_addr == 13'h000)      m_val = {21'd0, m_busy, m_err, m_busy, 8'd0};
      else if (req_addr == 13'h010) m_val = m_tim;
      else if (m_si >= 0)           m_val = (m_err || m_rlk[m_si / GSZ]) ? MARK : m_sh[m_si];
      m_start = !m_busy && !m_err &&
                (reload_req || (m_acc && req_write && req_addr == 13'h004 && req_wdata[10]));
      m_bad = m_acc && m_si >= 0 &&
              (req_write ? (m_busy || m_wlk[m_si / GSZ]) : m_rlk[m_si / GSZ]);
      m_clr = m_acc && req_write && req_addr == 13'h008 && req_wdata[9];
      m_shw = m_acc && req_write && m_si >= 0 && !m_busy && !m_wlk[m_si / GSZ] && !m_err;
      if (m_acc && !req_write) begin m_rv = 1; m_rd = m_val; end
      else if (rsp_ready) m_rv = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_sh[m_idx] = fuse_val(m_idx);
          if (m_idx == 0) begin m_pr = fuse_val(0)[15:0]; m_pw = fuse_val(0)[31:16]; end
          if (m_idx == NW - 1) begin m_busy = 0; m_rlk = m_pr; m_wlk = m_pw; end
          else m_idx++;
          m_cnt = int'(m_tim[21:16]);
        end else m_cnt--;
      end else if (m_start) begin
        m_busy = 1; m_idx = 0; m_cnt = int'(m_tim[21:16]);
      end
      if (m_shw) m_sh[m_si] = req_wdata;
      if (m_acc && req_write && req_addr == 13'h010) m_tim = req_wdata;
      if (m_clr) m_err = 0;
      else if (m_bad) m_err = 1;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R10 req_ready", {31'd0, req_ready}, {31'd0, (!m_rv || rsp_ready)});
      chk("R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
      if (m_rv) chk("R10 rsp_rdata", rsp_rdata, m_rd);
      chk("R3 reload_busy", {31'd0, reload_busy}, {31'd0, m_busy});
      chk("R4 fuse_rd_en", {31'd0, fuse_rd_en}, {31'd0, m_busy});
      if (m_busy) chk("R4 fuse_addr", {26'd0, fuse_addr}, 32'(m_idx));
    end
  end

  always @(negedge clk) if (reload_busy) busy_cnt++;

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic wait_idle();
    while (reload_busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(13'h000, rd); chk("R1 ctrl", rd, 32'h0);
    bus_rd(13'h010, rd); chk("R1 timing", rd, 32'h0002_0000);
    bus_rd(sa(5), rd);   chk("R1 shadow", rd, 32'h0);

    // R2 address map
    bus_wr(sa(3), 32'h1234_5678);
    bus_rd(sa(3), rd);          chk("R2 shadow rw", rd, 32'h1234_5678);
    bus_rd(sa(3) + 4, rd);      chk("R2 unaligned read", rd, 32'h0);
    bus_rd(sa(NW), rd);         chk("R2 out of range", rd, 32'h0);
    bus_wr(sa(3) + 8, 32'hFFFF);
    bus_rd(sa(3), rd);          chk("R2 unaligned write ignored", rd, 32'h1234_5678);

    // R3 start via set alias, R9 locks not yet active
    busy_cnt = 0;
    bus_wr(13'h004, 32'h400);
    bus_rd(13'h000, rd);        chk("R3 ctrl busy", rd, 32'h500);
    bus_rd(sa(9), rd);          chk("R9 lock not early", rd, 32'h0);
    repeat (12) @(negedge clk);
    bus_wr(sa(1), 32'hDEAD);    // R5 refused during reload
    bus_rd(13'h000, rd);        chk("R5 error set", rd, 32'h700);
    bus_rd(sa(10), rd);         chk("R8 marker while error", rd, MARK);
    wait_idle();
    chk("R4 busy length S=2", busy_cnt, NW * 3);
    bus_rd(13'h000, rd);        chk("R4 self clear, R8 sticky", rd, 32'h200);
    bus_wr(13'h008, 32'h200);
    bus_rd(13'h000, rd);        chk("R8 cleared", rd, 32'h0);
    bus_rd(sa(1), rd);          chk("R5 shadow unchanged", rd, fuse_val(1));
    bus_rd(sa(20), rd);         chk("R4 shadow loaded", rd, fuse_val(20));
    bus_rd(sa(NW - 1), rd);     chk("R4 last word", rd, fuse_val(NW - 1));

    // R7 / R9 read lock group 2
    bus_rd(sa(8), rd);          chk("R7 locked read", rd, MARK);
    bus_rd(13'h000, rd);        chk("R7 error", rd, 32'h200);
    bus_wr(13'h008, 32'h200);
    bus_rd(sa(7), rd);          chk("R9 group 1 open", rd, fuse_val(7));

    // R6 write lock group 3
    bus_wr(sa(12), 32'h1);
    bus_rd(13'h000, rd);        chk("R6 error", rd, 32'h200);
    bus_wr(13'h008, 32'h200);
    bus_rd(sa(12), rd);         chk("R6 unchanged", rd, fuse_val(12));
    bus_wr(sa(20), 32'h77);
    bus_rd(sa(20), rd);         chk("R6 unlocked write", rd, 32'h77);

    // R8 error gates reload sources and writes
    bus_rd(sa(8), rd);
    bus_wr(13'h004, 32'h400);
    bus_rd(13'h000, rd);        chk("R8 set ignored", rd, 32'h200);
    @(negedge clk) reload_req = 1;
    @(negedge clk) reload_req = 0;
    bus_rd(13'h000, rd);        chk("R8 pin ignored", rd, 32'h200);
    bus_wr(sa(20), 32'h99);
    bus_wr(13'h008, 32'h200);
    bus_rd(sa(20), rd);         chk("R8 write dropped", rd, 32'h77);

    // R4 strobe lengths 0 and 5
    bus_wr(13'h010, 32'h0);
    busy_cnt = 0;
    @(negedge clk) reload_req = 1;
    @(negedge clk) reload_req = 0;
    wait_idle();
    chk("R4 busy length S=0", busy_cnt, NW);
    bus_rd(sa(20), rd);         chk("R4 reload by pin", rd, fuse_val(20));
    bus_wr(13'h010, 32'h0005_0000);
    busy_cnt = 0;
    bus_wr(13'h004, 32'h400);
    wait_idle();
    chk("R4 busy length S=5", busy_cnt, NW * 6);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = sa(7);
    @(negedge clk);
    req_addr = sa(21);
    chk("R10 stall ready low", {31'd0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R10 held valid", {31'd0, rsp_valid}, 32'h1);
    chk("R10 held data", rsp_rdata, fuse_val(7));
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 queued read", rsp_rdata, fuse_val(21));
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule